// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic use an external 8192-word by 8-bit asynchronous static RAM. On the system side it takes one read or write request at a time through a valid/ready handshake, and it returns read data with a one-cycle valid pulse. On the memory side it drives a 13-bit address, three active-low strobes (chip select, write strobe, output gate) and the two halves of a split tristate data path: an output value with its enable, and an input value. The pad ring joins these into the shared bidirectional bus.

Each request becomes a fixed strobe sequence. The length of every phase is worked out from a clock period parameter and the memory's nanosecond minimums, rounded up to whole cycles, with at least one cycle per phase. A write is ended by the write strobe. The controller starts driving the bus only after the memory's worst-case output turn-off delay has passed since the write strobe fell, so the two sides never drive the bus at once. Between accesses all three strobes are high, which leaves the memory in standby.

Top module: `sram_xfer_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in idle: ready high, chip select, write strobe and output gate all high, bus drive enable low, and response valid low.
- R2: A request is taken only on a clock edge where valid and ready are both high. Ready drops in the cycle after acceptance and stays low until the sequence for that request is complete.
- R3: During a write, chip select and the write strobe are low and the output gate is high. The write strobe stays low for at least ceil(T_PWE_NS / CLK_PERIOD_NS) cycles.
- R4: The bus drive enable rises only after the write strobe has been low for ceil(T_HZWE_NS / CLK_PERIOD_NS) cycles, and at least one. It falls in the cycle after the write strobe rises. At no other time is the bus driven, and the controller never drives while the memory may still be driving.
- R5: Write data is driven and held stable for at least ceil(T_SD_NS / CLK_PERIOD_NS) cycles before the write strobe rises, and it is still driven in the cycle in which the strobe is high again.
- R6: During a read, chip select and the output gate are low and the write strobe is high, for max(ceil(T_AA_NS/T), ceil(T_DOE_NS/T), ceil(T_RC_NS/T)) cycles. The bus is sampled at the edge that ends the last of those cycles. Response valid is high for exactly the one following cycle, with the sample on the response data output.
- R7: The memory address holds the accepted request address, unchanged, for as long as chip select is low.
- R8: From acceptance, a write keeps ready low for at least ceil(T_WC_NS/T) cycles, and a read for at least ceil(T_RC_NS/T) cycles. Idle padding cycles with all strobes high are inserted when the strobe phases are shorter than that.
- R9: A read returns the value of the last completed write to the same address.
- R10: A request presented while ready is low has no effect: no access starts, and memory contents do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 13 | Word address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle pulse marking read data |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 13 | Address to the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output gate, active low |
| mem_dq_o | output | 8 | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 8 | Value read from the data bus |

## Verification
The situations hardest to reach from the ports are the bus hand-over and a request offered while the controller is busy. The bench's memory model keeps driving for one extra cycle after its output gate closes, and write requests are placed directly after reads, so any early drive shows up as contention. To test R10, a conflicting write is offered in the cycle right after each acceptance and then withdrawn before ready returns. A later read of that address then shows whether the offer leaked through. A reset placed in the middle of a write sequence checks that the strobes fall back to standby at once.

// File: rtl/sram_xfer_ctrl.sv
`timescale 1ns/1ps
module sram_xfer_ctrl #(
  parameter int ADDR_W        = 13,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_WC_NS       = 10,
  parameter int T_PWE_NS      = 8,
  parameter int T_SD_NS       = 8,
  parameter int T_HZWE_NS     = 6,
  parameter int T_RC_NS       = 10,
  parameter int T_AA_NS       = 10,
  parameter int T_DOE_NS      = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  localparam int P       = CLK_PERIOD_NS;
  localparam int WC_C0   = (T_WC_NS   + P - 1) / P;
  localparam int PWE_C0  = (T_PWE_NS  + P - 1) / P;
  localparam int SD_C0   = (T_SD_NS   + P - 1) / P;
  localparam int HZ_C0   = (T_HZWE_NS + P - 1) / P;
  localparam int RC_C0   = (T_RC_NS   + P - 1) / P;
  localparam int AA_C0   = (T_AA_NS   + P - 1) / P;
  localparam int DOE_C0  = (T_DOE_NS  + P - 1) / P;
  localparam int HZ_C    = HZ_C0 < 1 ? 1 : HZ_C0;
  localparam int SD_C    = SD_C0 < 1 ? 1 : SD_C0;
  localparam int PW_REST = PWE_C0 - HZ_C;
  localparam int WD_A    = SD_C > PW_REST ? SD_C : PW_REST;
  localparam int WD_C    = WD_A < 1 ? 1 : WD_A;
  localparam int WR_LEN  = HZ_C + WD_C + 1;
  localparam int PAD_C   = WC_C0 > WR_LEN ? WC_C0 - WR_LEN : 0;
  localparam int RD_A    = AA_C0 > DOE_C0 ? AA_C0 : DOE_C0;
  localparam int RD_B    = RD_A > RC_C0 ? RD_A : RC_C0;
  localparam int RD_C    = RD_B < 1 ? 1 : RD_B;
  localparam int MX_A    = HZ_C > WD_C ? HZ_C : WD_C;
  localparam int MX_B    = PAD_C > RD_C ? PAD_C : RD_C;
  localparam int MAX_LEN = MX_A > MX_B ? MX_A : MX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_WTURN, S_WDRV, S_WHOLD, S_PAD, S_RD
  } state_t;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic               last;

  assign last      = (cnt == '0);
  assign req_ready = (state == S_IDLE);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_ce_n  = (state == S_IDLE) || (state == S_PAD);
  assign mem_we_n  = !((state == S_WTURN) || (state == S_WDRV));
  assign mem_oe_n  = (state != S_RD);
  assign mem_dq_oe = (state == S_WDRV) || (state == S_WHOLD);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          if (req_write) begin
            state <= S_WTURN;
            cnt   <= CNT_W'(HZ_C - 1);
          end else begin
            state <= S_RD;
            cnt   <= CNT_W'(RD_C - 1);
          end
        end
        S_WTURN: if (last) begin
          state <= S_WDRV;
          cnt   <= CNT_W'(WD_C - 1);
        end else cnt <= cnt - 1'b1;
        S_WDRV: if (last) state <= S_WHOLD;
                else cnt <= cnt - 1'b1;
        S_WHOLD: if (PAD_C > 0) begin
          state <= S_PAD;
          cnt   <= CNT_W'(PAD_C > 0 ? PAD_C - 1 : 0);
        end else state <= S_IDLE;
        S_PAD: if (last) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        S_RD: if (last) begin
          rsp_rdata <= mem_dq_i;
          rsp_valid <= 1'b1;
          state     <= S_IDLE;
        end else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);
  // R3
  gate_shut_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n));
  // R4
  drive_after_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> ($past(!mem_we_n) && !mem_we_n));
  // R4
  quiet_at_strobe_fall_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_we_n) |-> !mem_dq_oe);
  // R5
  data_steady_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_o));
  // R6
  rsp_single_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

endmodule

// File: tb/sram_xfer_ctrl_tb.sv
`timescale 1ns/1ps
module sram_xfer_ctrl_tb;
  localparam int P = 5, T_WC = 10, T_PWE = 8, T_SD = 8, T_HZ = 6;
  localparam int T_RC = 10, T_AA = 10, T_DOE = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, ce_n, we_n, oe_n, dq_oe;
  logic [7:0] rsp_rdata, dq_o, bus, rd_val;
  logic [12:0] mem_addr;
  logic mem_drv, mem_drv_d;

  always #2.5 clk = ~clk;

  sram_xfer_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_dq_o(dq_o),
    .mem_dq_oe(dq_oe), .mem_dq_i(bus));

  assign mem_drv = !ce_n && we_n && !oe_n;
  assign bus = dq_oe ? dq_o : (mem_drv ? rd_val : 8'hzz);
  always @(posedge clk) mem_drv_d <= mem_drv;

  typedef struct {
    logic ce, we, oe, drv;
    logic [12:0] a;
    logic [7:0] d;
    bit rlast;
    logic [7:0] rexp;
  } step_t;

  step_t q[$];
  logic [7:0] mdl [int];
  logic [7:0] sb  [int];
  int total = 0, bad = 0, cycles = 0;
  int hz_n, wd_n, pad_n, rd_n;
  bit chk_on = 0, rsp_due = 0;
  logic [7:0] rsp_exp, last_d;
  logic [12:0] last_a;
  int we_low = 0, drv_run = 0;
  logic prev_we = 1'b1;

  function automatic int up(int ns);
    int c = (ns + P - 1) / P;
    return c < 1 ? 1 : c;
  endfunction

  function automatic int mx(int a, int b);
    return a > b ? a : b;
  endfunction

  function automatic logic [7:0] mget(logic [12:0] a);
    return mdl.exists(int'(a)) ? mdl[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] sget(logic [12:0] a);
    return sb.exists(int'(a)) ? sb[int'(a)] : 8'h00;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic step_t mk(logic ce, logic we, logic oe, logic drv,
                               logic [12:0] a, logic [7:0] d);
    step_t s;
    s.ce = ce; s.we = we; s.oe = oe; s.drv = drv;
    s.a = a; s.d = d; s.rlast = 0; s.rexp = '0;
    return s;
  endfunction

  initial begin
    hz_n  = up(T_HZ);
    wd_n  = mx(mx(up(T_SD), up(T_PWE) - hz_n), 1);
    pad_n = mx(up(T_WC) - (hz_n + wd_n + 1), 0);
    rd_n  = mx(mx(up(T_AA), up(T_DOE)), up(T_RC));
  end

  always @(negedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(negedge clk) if (chk_on) begin
    step_t e;
    bit busy;
    busy = (q.size() > 0);
    if (busy) e = q.pop_front();
    else e = mk(1, 1, 1, 0, '0, '0);
    // R8: ready tracks the expected sequence length
    chk(req_ready == !busy, "R8", "ready", req_ready, !busy);
    // R3
    chk(ce_n == e.ce, "R3", "chip select", ce_n, e.ce);
    chk(we_n == e.we, "R3", "write strobe", we_n, e.we);
    // R6
    chk(oe_n == e.oe, "R6", "output gate", oe_n, e.oe);
    // R4
    chk(dq_oe == e.drv, "R4", "bus drive", dq_oe, e.drv);
    // R5
    if (e.drv) chk(dq_o == e.d, "R5", "drive data", dq_o, e.d);
    // R7
    if (!e.ce) chk(mem_addr == e.a, "R7", "address", mem_addr, e.a);
    // R6
    chk(rsp_valid == rsp_due, "R6", "response valid", rsp_valid, rsp_due);
    // R9
    if (rsp_due) chk(rsp_rdata == rsp_exp, "R9", "read data", rsp_rdata, rsp_exp);
    rsp_due = 0;
    if (e.rlast) begin rsp_due = 1; rsp_exp = e.rexp; end
    // R4: no contention with memory output or its turn-off tail
    chk(!(dq_oe && (mem_drv || mem_drv_d)), "R4", "contention", dq_oe, 0);
    if (!we_n && !ce_n) begin
      we_low++;
      if (dq_oe) drv_run = (drv_run > 0 && dq_o == last_d) ? drv_run + 1 : 1;
      else drv_run = 0;
      last_d = dq_o;
      last_a = mem_addr;
    end
    if (!prev_we && we_n && !ce_n) begin
      // R3
      chk(we_low * P >= T_PWE, "R3", "strobe width ns", we_low * P, T_PWE);
      // R5
      chk(drv_run * P >= T_SD, "R5", "data setup ns", drv_run * P, T_SD);
      chk(dq_oe && dq_o == last_d, "R5", "data hold", dq_o, last_d);
      mdl[int'(last_a)] = last_d;
    end
    if (we_n) begin we_low = 0; drv_run = 0; end
    prev_we = we_n;
    if (mem_drv) rd_val = mget(mem_addr);
    if (rst) begin
      q.delete();
      rsp_due = 0;
    end else if (req_valid && req_ready) begin
      if (req_write) begin
        for (int i = 0; i < hz_n; i++) q.push_back(mk(0, 0, 1, 0, req_addr, req_wdata));
        for (int i = 0; i < wd_n; i++) q.push_back(mk(0, 0, 1, 1, req_addr, req_wdata));
        q.push_back(mk(0, 1, 1, 1, req_addr, req_wdata));
        for (int i = 0; i < pad_n; i++) q.push_back(mk(1, 1, 1, 0, req_addr, req_wdata));
        sb[int'(req_addr)] = req_wdata;
      end else begin
        for (int i = 0; i < rd_n; i++) begin
          step_t s;
          s = mk(0, 1, 0, 0, req_addr, '0);
          if (i == rd_n - 1) begin s.rlast = 1; s.rexp = sget(req_addr); end
          q.push_back(s);
        end
      end
    end
  end

  task automatic issue(bit w, logic [12:0] a, logic [7:0] d);
    @(posedge clk); #1;
    while (!req_ready) begin @(posedge clk); #1; end
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  task automatic rd_expect(logic [12:0] a, logic [7:0] exp, string tag);
    issue(0, a, 8'h00);
    do begin @(posedge clk); #1; end while (!rsp_valid);
    chk(rsp_rdata == exp, tag, "read back", rsp_rdata, exp);
  endtask

  task automatic wr_with_intruder(logic [12:0] a, logic [7:0] d, logic [7:0] junk);
    issue(1, a, d);
    req_valid = 1; req_write = 1; req_wdata = junk;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(req_ready && ce_n && we_n && oe_n && !dq_oe && !rsp_valid, "R1", "reset state",
        {req_ready, ce_n, we_n, oe_n, dq_oe, rsp_valid}, 6'b111100);
    rst = 0;
    chk_on = 1;
    issue(1, 13'd0, 8'h5A);
    issue(1, 13'h1FFF, 8'hA5);
    rd_expect(13'd0, 8'h5A, "R9");
    rd_expect(13'h1FFF, 8'hA5, "R9");
    issue(1, 13'd0, 8'hFF);
    rd_expect(13'd0, 8'hFF, "R9");
    rd_expect(13'd100, 8'h00, "R9");
    issue(1, 13'd7, 8'h00);
    rd_expect(13'd7, 8'h00, "R9");
    // R10: an offer made while busy must not land
    wr_with_intruder(13'd20, 8'h11, 8'h99);
    rd_expect(13'd20, 8'h11, "R10");
    issue(0, 13'd20, 8'h00);
    req_valid = 1; req_write = 1; req_addr = 13'd21; req_wdata = 8'h66;
    @(posedge clk); #1;
    req_valid = 0;
    rd_expect(13'd21, 8'h00, "R10");
    // R1: reset in the middle of a write
    issue(1, 13'd30, 8'h77);
    rst = 1;
    @(posedge clk); #1;
    chk(req_ready && ce_n && we_n && oe_n && !dq_oe, "R1", "reset mid write",
        {req_ready, ce_n, we_n, oe_n, dq_oe}, 5'b11110);
    rst = 0;
    issue(1, 13'd30, 8'h31);
    rd_expect(13'd30, 8'h31, "R1");
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[0]) issue(1, {8'h00, lfsr[5:1]}, lfsr[15:8]);
      else issue(0, {8'h00, lfsr[5:1]}, 8'h00);
      if (lfsr[7:6] == 2'b11) begin
        req_valid = 1; req_write = 1; req_addr = {8'h00, lfsr[12:8]}; req_wdata = 8'hEE;
        @(posedge clk); #1;
        req_valid = 0;
      end
    end
    repeat (20) @(posedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule